// File: doc/BRIEF.md
# FSK End-of-Message Detector

This block watches a received FSK character stream and raises a sticky end-of-message flag, so that the equipment can restore its voice path soon after the data burst stops. End of carrier alone is an unreliable sign in a noisy line, so three separate end conditions are used. The first is carrier loss. The second is too many characters whose trailing stop bit came in as 0. The third is a demodulated level that has stayed at mark or at space for too long.

A rising edge on the carrier-present input starts a message. It clears both counters and arms the detector. The flag stays high once it is set, and only the next carrier rising edge clears it. All end conditions reach the flag within two clock cycles, which is far inside the 50 ms budget for restoring the voice path.

The controller has three states. `S_IDLE` is the state after reset and has not been armed. `S_LISTEN` watches the message. `S_ENDED` holds the flag. The transitions are:
- `T_ARM`: `S_IDLE` to `S_LISTEN` on a carrier rising edge.
- `T_LOSS`, `T_FRAMING` and `T_STEADY`: `S_LISTEN` to `S_ENDED`, one for each end condition.
- `T_REARM`: `S_ENDED` to `S_LISTEN` on a carrier rising edge.

Top module: `fsk_eom_detect`

## Requirements
- R1: After reset the end flag is low and stays low until a message has been armed and then ended.
- R2: A carrier rising edge (low in one sampled cycle, high in the next) starts a message. The flag reads low from the next clock edge, and both the error count and the level timer restart from zero.
- R3: While listening, a cycle with carrier low sets the flag at the next clock edge.
- R4: A framing error is a cycle with `char_done_i` high and `stop_bit_i` at 0. A strobe with `stop_bit_i` at 1 is not counted.
- R5: Five framing errors in one message never end it. The sixth sets the flag at the second clock edge after the strobe cycle that carries it.
- R6: Millisecond ticks are counted while `rx_bit_i` holds one value. After 150 ticks without a change the flag is still low. The 151st tick sets the flag at the second clock edge after the tick cycle.
- R7: Any change of `rx_bit_i` between sampled cycles restarts the level timer from zero.
- R8: Counts do not carry over between messages. Errors and ticks gathered before a re-arm do not count toward the next message.
- R9: Once set, the flag stays high whatever the bit, strobe, tick or a steady-high carrier do, until a carrier rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| carrier_i | input | 1 | Carrier present |
| rx_bit_i | input | 1 | Demodulated bit level (1 = mark, 0 = space) |
| char_done_i | input | 1 | One-cycle strobe per received character |
| stop_bit_i | input | 1 | Stop bit value of the character, valid with `char_done_i` |
| ms_tick_i | input | 1 | One-cycle pulse each millisecond |
| fsk_end_o | output | 1 | Sticky end-of-message flag |

## Verification
The bench probes the exact boundaries. It sends five errors and then a sixth, and 150 ticks and then a 151st, and checks both the cycle before the flag rises and the cycle it rises. A design with an off-by-one threshold would end one event early or one event late. A level change placed deep into a quiet run catches a timer that does not restart and so ends too early. A re-arm followed by a single error catches counts that leak from one message into the next. Bit, strobe and tick activity while the flag is held, with the carrier steady high, catches a flag that clears without a real new start.

// File: rtl/eom_pkg.sv
package eom_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_LISTEN = 2'd1,
        S_ENDED  = 2'd2
    } eom_state_t;

endpackage

// File: rtl/eom_rise_detect.sv
module eom_rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);
    logic sig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig_i;
    end

    assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/eom_fault_tally.sv
module eom_fault_tally #(
    parameter int LIMIT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic enable_i,
    input  logic strobe_i,
    input  logic stop_ok_i,
    output logic over_o
);
    localparam int CW = $clog2(LIMIT + 2);
    localparam logic [CW-1:0] SAT = CW'(LIMIT + 1);
    localparam logic [CW-1:0] TOP = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear_i)
            cnt_q <= '0;
        else if (enable_i && strobe_i && !stop_ok_i && cnt_q != SAT)
            cnt_q <= cnt_q + CW'(1);
    end

    assign over_o = (cnt_q > TOP);

    // R4
    tally_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> (CW'(cnt_q - $past(cnt_q)) <= CW'(1)));

    // R4
    tally_good_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && stop_ok_i) |=> $stable(cnt_q));
endmodule

// File: rtl/eom_quiet_timer.sv
module eom_quiet_timer #(
    parameter int SPAN = 150
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic enable_i,
    input  logic tick_i,
    input  logic level_i,
    output logic over_o
);
    localparam int TW = $clog2(SPAN + 2);
    localparam logic [TW-1:0] SAT = TW'(SPAN + 1);
    localparam logic [TW-1:0] TOP = TW'(SPAN);

    logic [TW-1:0] cnt_q;
    logic          level_q;
    logic          toggle;

    assign toggle = level_i ^ level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear_i || toggle)
            cnt_q <= '0;
        else if (enable_i && tick_i && cnt_q != SAT)
            cnt_q <= cnt_q + TW'(1);
    end

    assign over_o = (cnt_q > TOP);

    // R6
    quiet_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> (cnt_q == '0 || TW'(cnt_q - $past(cnt_q)) <= TW'(1)));
endmodule

// File: rtl/fsk_eom_detect.sv
module fsk_eom_detect
    import eom_pkg::*;
#(
    parameter int FE_LIMIT = 5,
    parameter int RUN_MS   = 150
) (
    input  logic clk,
    input  logic rst_n,
    input  logic carrier_i,
    input  logic rx_bit_i,
    input  logic char_done_i,
    input  logic stop_bit_i,
    input  logic ms_tick_i,
    output logic fsk_end_o
);
    eom_state_t state_q, state_d;
    logic       start;
    logic       listening;
    logic       fe_over;
    logic       run_over;

    eom_rise_detect u_start (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (carrier_i),
        .rise_o (start)
    );

    assign listening = (state_q == S_LISTEN);

    eom_fault_tally #(.LIMIT(FE_LIMIT)) u_tally (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (start),
        .enable_i  (listening),
        .strobe_i  (char_done_i),
        .stop_ok_i (stop_bit_i),
        .over_o    (fe_over)
    );

    eom_quiet_timer #(.SPAN(RUN_MS)) u_quiet (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (start),
        .enable_i (listening),
        .tick_i   (ms_tick_i),
        .level_i  (rx_bit_i),
        .over_o   (run_over)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = S_LISTEN;             // T_ARM
            S_LISTEN: begin
                if (!carrier_i)    state_d = S_ENDED;            // T_LOSS
                else if (fe_over)  state_d = S_ENDED;            // T_FRAMING
                else if (run_over) state_d = S_ENDED;            // T_STEADY
            end
            S_ENDED:  if (start) state_d = S_LISTEN;             // T_REARM
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        fsk_end_o = (state_q == S_ENDED);
    end

    // R3
    loss_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (listening && !carrier_i) |=> fsk_end_o);

    // R5
    framing_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (listening && fe_over) |=> fsk_end_o);

    // R6
    steady_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (listening && run_over) |=> fsk_end_o);

    // R9
    flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsk_end_o && !start) |=> fsk_end_o);

    // R2
    rearm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !fsk_end_o);
endmodule

// File: tb/fsk_eom_detect_test.sv
module fsk_eom_detect_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic carrier_i = 1'b0;
    logic rx_bit_i = 1'b1;
    logic char_done_i = 1'b0;
    logic stop_bit_i = 1'b1;
    logic ms_tick_i = 1'b0;
    logic fsk_end_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string phase = "R1";

    // reference model state
    bit m_active = 0, m_ended = 0, m_pcar = 0, m_pbit = 0;
    int m_errs = 0, m_quiet = 0;

    always #10 clk = ~clk;

    fsk_eom_detect uut (
        .clk(clk), .rst_n(rst_n), .carrier_i(carrier_i), .rx_bit_i(rx_bit_i),
        .char_done_i(char_done_i), .stop_bit_i(stop_bit_i), .ms_tick_i(ms_tick_i),
        .fsk_end_o(fsk_end_o)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_active = 0; m_ended = 0; m_pcar = 0; m_pbit = 0; m_errs = 0; m_quiet = 0;
        end else begin
            if (carrier_i && !m_pcar) begin
                m_active = 1; m_ended = 0; m_errs = 0; m_quiet = 0;
            end else if (m_active) begin
                if (!carrier_i || m_errs > 5 || m_quiet > 150) begin
                    m_active = 0; m_ended = 1;
                end else begin
                    if (char_done_i && !stop_bit_i && m_errs < 6) m_errs++;
                    if (rx_bit_i != m_pbit) m_quiet = 0;
                    else if (ms_tick_i && m_quiet < 151) m_quiet++;
                end
            end
            m_pcar = carrier_i;
            m_pbit = rx_bit_i;
        end
    end

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: fsk_end_o=%0b expected %0b at cycle %0d", req, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (rst_n) check(fsk_end_o, m_ended, phase);
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic tick;
        ms_tick_i = 1'b1; step(1); ms_tick_i = 1'b0; step(3);
    endtask

    task automatic strobe(input logic stop);
        char_done_i = 1'b1; stop_bit_i = stop; step(1);
        char_done_i = 1'b0; stop_bit_i = 1'b1; step(2);
    endtask

    task automatic rearm;
        carrier_i = 1'b0; step(2); carrier_i = 1'b1; step(2);
    endtask

    initial begin
        step(3);
        check(fsk_end_o, 1'b0, "R1");
        rst_n = 1'b1;
        step(5);
        check(fsk_end_o, 1'b0, "R1");

        phase = "R2"; carrier_i = 1'b1; step(2);
        check(fsk_end_o, 1'b0, "R2");

        phase = "R4";
        for (int i = 0; i < 10; i++) strobe(1'b1);
        check(fsk_end_o, 1'b0, "R4");

        phase = "R7";
        for (int i = 0; i < 400; i++) begin
            if (i % 20 == 0) rx_bit_i = ~rx_bit_i;
            tick;
        end
        check(fsk_end_o, 1'b0, "R7");

        phase = "R5";
        for (int i = 0; i < 5; i++) strobe(1'b0);
        step(4);
        check(fsk_end_o, 1'b0, "R5");
        char_done_i = 1'b1; stop_bit_i = 1'b0; step(1);
        char_done_i = 1'b0; stop_bit_i = 1'b1;
        check(fsk_end_o, 1'b0, "R5");
        step(1);
        check(fsk_end_o, 1'b1, "R5");

        phase = "R9";
        for (int i = 0; i < 20; i++) begin
            rx_bit_i = ~rx_bit_i; strobe(1'b0); tick;
        end
        check(fsk_end_o, 1'b1, "R9");

        phase = "R8"; rearm;
        check(fsk_end_o, 1'b0, "R2");
        strobe(1'b0); step(4);
        check(fsk_end_o, 1'b0, "R8");

        phase = "R6";
        rx_bit_i = ~rx_bit_i; step(2);
        for (int i = 0; i < 150; i++) tick;
        check(fsk_end_o, 1'b0, "R6");
        ms_tick_i = 1'b1; step(1); ms_tick_i = 1'b0;
        check(fsk_end_o, 1'b0, "R6");
        step(1);
        check(fsk_end_o, 1'b1, "R6");

        phase = "R7"; rearm;
        for (int i = 0; i < 100; i++) tick;
        rx_bit_i = ~rx_bit_i; step(1);
        for (int i = 0; i < 150; i++) tick;
        check(fsk_end_o, 1'b0, "R7");
        tick;
        check(fsk_end_o, 1'b1, "R7");

        phase = "R3"; rearm;
        check(fsk_end_o, 1'b0, "R2");
        carrier_i = 1'b0; step(1);
        check(fsk_end_o, 1'b1, "R3");
        step(3);
        check(fsk_end_o, 1'b1, "R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule